// File: doc/BRIEF.md
# Unified Shader Vertex/Pixel Issue Arbiter

This block decides, cycle by cycle, whether the next free ALU slot of a unified shader goes to a vertex thread or to a pixel thread. Pixel work normally wins, because shaded pixels leave the machine while waiting pixels occupy storage. Vertex work takes over in several cases: when every pending pixel thread is blocked on texture fetches, when the estimated remaining pixel work falls below a programmable level, and when the render state needs no colour output at all. Starting vertex work early in these cases keeps the rasterizer supplied with new fragments, so the ALUs do not run out of work.

A second handshake admits new triangles into the shared register block. The arbiter checks the reported occupancy and also counts the vertices it admitted in the previous cycle, because that admission does not yet appear in the occupancy input. Admitted vertex threads stay resident until the arbiter grants them. A simple fallback mode is also provided. In this mode the arbiter alternates between two phases. It runs vertices until the transformed-vertex buffer reports full, and then it serves pixels.

Top module: `shader_issue_arb`

## Requirements
- R1: A synchronous active-high reset clears the remaining-cost counter, the pending-admission count and the fallback phase. After reset, with both thread types eligible and no cost estimate loaded, the pixel thread is granted.
- R2: When both types are eligible and no override applies, the pixel thread is granted (`grant_vtx`=0, `pix_ready`=1).
- R3: `tri_ready` is asserted only if `rb_used` plus the vertex count admitted in the previous cycle plus `tri_nverts` does not exceed `RB_SLOTS`.
- R4: While `pix_stalled` is high, a waiting, eligible vertex thread gets the free slot.
- R5: `cost_load` loads `cost_value` into a remaining-cost counter, and loading takes precedence over decrementing. Each pixel grant decrements the counter by one, and the counter stops at zero. Once a value has been loaded, a vertex thread beats a pixel thread whenever the counter is below `cost_thresh`.
- R6: When `fallback_mode` is set, the arbiter enters its vertex phase when it grants a vertex and leaves it when `vbuf_full` is seen. During the vertex phase vertices beat pixels, and the cost threshold is ignored.
- R7: While `depth_only` is high, no pixel thread is ever granted.
- R8: No vertex grant is issued while `vbuf_full` is high, and no pixel grant is issued while `pix_full` is high.
- R9: At most one slot is granted per cycle, and it is always the lowest-numbered free slot (bit 0 = slot 0). No grant is issued when no slot is free or when no thread is eligible.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_free | input | N_SLOTS | Free ALU slots, bit i = slot i |
| tri_valid | input | 1 | A triangle is waiting to enter the register block |
| tri_nverts | input | 2 | Vertices the triangle needs (1 to 3) |
| tri_ready | output | 1 | Triangle admitted this cycle |
| rb_used | input | RB_W | Register-block occupancy, one cycle late |
| vtx_valid | input | 1 | A resident vertex thread is waiting |
| vtx_ready | output | 1 | Vertex thread granted this cycle |
| vbuf_full | input | 1 | Transformed-vertex buffer is full |
| pix_valid | input | 1 | A pixel thread is waiting |
| pix_ready | output | 1 | Pixel thread granted this cycle |
| pix_stalled | input | 1 | All pending pixel threads are waiting on texture |
| pix_full | input | 1 | Pixel downstream buffer is full |
| cost_load | input | 1 | Load a new remaining-cost estimate |
| cost_value | input | COST_W | Per-batch remaining pixel cost |
| cost_thresh | input | COST_W | Early-vertex threshold |
| depth_only | input | 1 | Colour writes and alpha test are both off |
| fallback_mode | input | 1 | Select the fill-then-switch policy |
| slot_grant | output | N_SLOTS | One-hot granted slot |
| grant_vtx | output | 1 | Grant is for a vertex thread |

## Verification
The central choice between vertex and pixel is driven with both types waiting and with one override raised at a time: texture stall, a cost counter counted down across its threshold, depth-only, and fallback phase. Each case separates one override path from the pixel-first default. Back-pressure patterns show that a full buffer blocks only its own type. Free-slot masks with gaps check the choice of slot. A sequence of triangle admissions shows that the previous cycle's admission is counted even though the occupancy input has not yet caught up.

// File: rtl/shader_issue_arb.sv
module shader_issue_arb #(
  parameter int N_SLOTS  = 4,
  parameter int RB_SLOTS = 16,
  parameter int COST_W   = 16,
  localparam int RB_W    = $clog2(RB_SLOTS + 1),
  localparam int SUM_W   = RB_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] slot_free,
  input  logic               tri_valid,
  input  logic [1:0]         tri_nverts,
  output logic               tri_ready,
  input  logic [RB_W-1:0]    rb_used,
  input  logic               vtx_valid,
  output logic               vtx_ready,
  input  logic               vbuf_full,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic               pix_stalled,
  input  logic               pix_full,
  input  logic               cost_load,
  input  logic [COST_W-1:0]  cost_value,
  input  logic [COST_W-1:0]  cost_thresh,
  input  logic               depth_only,
  input  logic               fallback_mode,
  output logic [N_SLOTS-1:0] slot_grant,
  output logic               grant_vtx
);

  logic [1:0]        pend;
  logic [COST_W-1:0] cost_cnt;
  logic              cost_valid;
  logic              fb_vtx;

  logic [SUM_W-1:0]   rb_need;
  logic [N_SLOTS-1:0] low_free;
  logic any_free, vtx_elig, pix_elig, early, pick_vtx, pick_pix;

  assign rb_need   = SUM_W'(rb_used) + SUM_W'(pend) + SUM_W'(tri_nverts);
  assign tri_ready = tri_valid && (rb_need <= SUM_W'(RB_SLOTS));

  assign low_free  = slot_free & (~slot_free + N_SLOTS'(1));
  assign any_free  = |slot_free;

  assign vtx_elig  = vtx_valid && !vbuf_full;
  assign pix_elig  = pix_valid && !pix_stalled && !pix_full && !depth_only;
  assign early     = cost_valid && (cost_cnt < cost_thresh);

  assign pick_vtx  = vtx_elig && (!pix_elig || (fallback_mode ? fb_vtx : early));
  assign pick_pix  = pix_elig && !pick_vtx;

  assign vtx_ready  = any_free && pick_vtx;
  assign pix_ready  = any_free && pick_pix;
  assign grant_vtx  = vtx_ready;
  assign slot_grant = (vtx_ready || pix_ready) ? low_free : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      cost_cnt   <= '0;
      cost_valid <= 1'b0;
      fb_vtx     <= 1'b0;
    end else begin
      pend <= tri_ready ? tri_nverts : 2'd0;

      if (cost_load) begin
        cost_cnt   <= cost_value;
        cost_valid <= 1'b1;
      end else if (pix_ready && cost_cnt != '0) begin
        cost_cnt <= cost_cnt - COST_W'(1);
      end

      if (!fallback_mode)              fb_vtx <= 1'b0;
      else if (fb_vtx && vbuf_full)    fb_vtx <= 1'b0;
      else if (!fb_vtx && vtx_ready)   fb_vtx <= 1'b1;
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_grant) && ((slot_grant & ~slot_free) == '0));

  assert_grant_needs_thread_R9: assert property (@(posedge clk) disable iff (rst)
    (slot_grant != '0) |-> (vtx_ready || pix_ready));

  assert_rb_room_R3: assert property (@(posedge clk) disable iff (rst)
    tri_ready |-> (SUM_W'(rb_used) + SUM_W'(tri_nverts) <= SUM_W'(RB_SLOTS)));

  assert_stall_to_vtx_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_stalled && vtx_valid && !vbuf_full && any_free) |-> vtx_ready);

  assert_cost_step_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cost_valid) && !$past(cost_load) && $past(pix_ready) && $past(cost_cnt) != '0)
      |-> (cost_cnt == $past(cost_cnt) - COST_W'(1)));

  assert_depth_only_R7: assert property (@(posedge clk) disable iff (rst)
    depth_only |-> !pix_ready);

  assert_vbuf_block_R8: assert property (@(posedge clk) disable iff (rst)
    vbuf_full |-> !vtx_ready);

  assert_pbuf_block_R8: assert property (@(posedge clk) disable iff (rst)
    pix_full |-> !pix_ready);

  assert_fb_leave_R6: assert property (@(posedge clk) disable iff (rst)
    (fallback_mode && fb_vtx && vbuf_full) |=> !fb_vtx);

endmodule

// File: tb/shader_issue_arb_bench.sv
module shader_issue_arb_bench;
  logic       clk = 0;
  logic       rst;
  logic [3:0] slot_free;
  logic       tri_valid;
  logic [1:0] tri_nverts;
  logic       tri_ready;
  logic [4:0] rb_used;
  logic       vtx_valid, vtx_ready, vbuf_full;
  logic       pix_valid, pix_ready, pix_stalled, pix_full;
  logic       cost_load;
  logic [15:0] cost_value, cost_thresh;
  logic       depth_only, fallback_mode;
  logic [3:0] slot_grant;
  logic       grant_vtx;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  shader_issue_arb u_shader_issue_arb (
    .clk(clk), .rst(rst), .slot_free(slot_free),
    .tri_valid(tri_valid), .tri_nverts(tri_nverts), .tri_ready(tri_ready),
    .rb_used(rb_used), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
    .vbuf_full(vbuf_full), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_stalled(pix_stalled), .pix_full(pix_full), .cost_load(cost_load),
    .cost_value(cost_value), .cost_thresh(cost_thresh), .depth_only(depth_only),
    .fallback_mode(fallback_mode), .slot_grant(slot_grant), .grant_vtx(grant_vtx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {vtx_ready, pix_ready, grant_vtx, slot_grant}
  function automatic logic [31:0] gr();
    return {25'd0, vtx_ready, pix_ready, grant_vtx, slot_grant};
  endfunction

  function automatic logic [31:0] want(input logic v, input logic p, input logic [3:0] s);
    return {25'd0, v, p, v, s};
  endfunction

  task automatic idle_inputs();
    slot_free = 4'b1111; tri_valid = 0; tri_nverts = 0; rb_used = 0;
    vtx_valid = 0; vbuf_full = 0; pix_valid = 0; pix_stalled = 0; pix_full = 0;
    cost_load = 0; cost_value = 0; cost_thresh = 0; depth_only = 0; fallback_mode = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    vtx_valid = 1; pix_valid = 1; cost_thresh = 16'd100;
    #2 chk("R1 pixel first after reset", gr(), want(0, 1, 4'b0001));
    chk("R1 no admission idle", {31'd0, tri_ready}, 0);
  endtask

  task automatic t_priority_slots();
    do_reset();
    @(negedge clk); vtx_valid = 1; pix_valid = 1;
    #2 chk("R2 pixel beats vertex", gr(), want(0, 1, 4'b0001));
    @(negedge clk); slot_free = 4'b1100;
    #2 chk("R9 lowest free slot", gr(), want(0, 1, 4'b0100));
    @(negedge clk); slot_free = 4'b0000;
    #2 chk("R9 no free slot", gr(), want(0, 0, 4'b0000));
    @(negedge clk); slot_free = 4'b1010; pix_valid = 0;
    #2 chk("R9 vertex alone slot1", gr(), want(1, 0, 4'b0010));
    @(negedge clk); vtx_valid = 0;
    #2 chk("R9 no thread ready", gr(), want(0, 0, 4'b0000));
  endtask

  task automatic t_triangle();
    do_reset();
    @(negedge clk); tri_valid = 1; rb_used = 5'd14; tri_nverts = 2'd3;
    #2 chk("R3 too few spare slots", {31'd0, tri_ready}, 0);
    @(negedge clk); tri_nverts = 2'd2;
    #2 chk("R3 exact fit admitted", {31'd0, tri_ready}, 1);
    @(negedge clk); tri_nverts = 2'd1;
    #2 chk("R3 last-cycle admission counted", {31'd0, tri_ready}, 0);
    @(negedge clk);
    #2 chk("R3 admission after pending clears", {31'd0, tri_ready}, 1);
  endtask

  task automatic t_stall_full();
    do_reset();
    @(negedge clk); vtx_valid = 1; pix_valid = 1; pix_stalled = 1;
    #2 chk("R4 texture stall yields vertex", gr(), want(1, 0, 4'b0001));
    @(negedge clk); pix_stalled = 0; vbuf_full = 1; pix_valid = 0;
    #2 chk("R8 vbuf full blocks vertex", gr(), want(0, 0, 4'b0000));
    @(negedge clk); vbuf_full = 0; vtx_valid = 0; pix_valid = 1; pix_full = 1;
    #2 chk("R8 pix full blocks pixel", gr(), want(0, 0, 4'b0000));
    @(negedge clk); vtx_valid = 1;
    #2 chk("R8 pix full lets vertex through", gr(), want(1, 0, 4'b0001));
  endtask

  task automatic t_depth_only();
    do_reset();
    @(negedge clk); vtx_valid = 1; pix_valid = 1; depth_only = 1;
    #2 chk("R7 depth-only to vertex", gr(), want(1, 0, 4'b0001));
    @(negedge clk); vtx_valid = 0;
    #2 chk("R7 depth-only no pixel grant", gr(), want(0, 0, 4'b0000));
  endtask

  task automatic t_cost();
    do_reset();
    @(negedge clk); vtx_valid = 1; pix_valid = 1; cost_thresh = 16'd3;
    cost_load = 1; cost_value = 16'd5;
    #2 chk("R5 load cycle pixel", gr(), want(0, 1, 4'b0001));
    @(negedge clk); cost_load = 0;
    #2 chk("R5 cost 5 pixel", gr(), want(0, 1, 4'b0001));
    @(negedge clk);
    #2 chk("R5 cost 4 pixel", gr(), want(0, 1, 4'b0001));
    @(negedge clk); slot_free = 4'b0000;
    #2 chk("R5 cost 3 no slot", gr(), want(0, 0, 4'b0000));
    @(negedge clk); slot_free = 4'b1111;
    #2 chk("R5 cost 3 held pixel", gr(), want(0, 1, 4'b0001));
    @(negedge clk);
    #2 chk("R5 cost 2 early vertex", gr(), want(1, 0, 4'b0001));
  endtask

  task automatic t_fallback();
    do_reset();
    @(negedge clk); fallback_mode = 1; vtx_valid = 1; pix_valid = 0;
    #2 chk("R6 vertex enters phase", gr(), want(1, 0, 4'b0001));
    @(negedge clk); pix_valid = 1;
    #2 chk("R6 vertex phase beats pixel", gr(), want(1, 0, 4'b0001));
    @(negedge clk); vbuf_full = 1;
    #2 chk("R6 buffer full gives pixel", gr(), want(0, 1, 4'b0001));
    @(negedge clk); vbuf_full = 0;
    #2 chk("R6 pixel phase after full", gr(), want(0, 1, 4'b0001));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; idle_inputs();
    t_reset();
    t_priority_slots();
    t_triangle();
    t_stall_full();
    t_depth_only();
    t_cost();
    t_fallback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule